// File: doc/BRIEF.md
# Time-Multiplexed Shared Word RAM

This block is a 1024-word by 32-bit data memory that three requesters share by time division: a byte-addressed processor port, a full-word compute engine port and a full-word SPI slave port. The memory clock runs four times faster than the system clock. Each system-clock period is therefore a frame of four memory cycles, and each cycle is a slot owned by one requester. The slots always come in this order: processor slot A, processor slot B, compute engine, SPI.

The processor addresses bytes. A byte read fetches the containing word in slot A, and a lane multiplexer returns the addressed byte. A byte write also fetches the word in slot A. In slot B it writes the word back with only the addressed byte replaced. The processor never issues two memory accesses back to back except to the same address, so slot B is always free for this second access.

The `frame_start` output marks the cycle of slot A, so requesters can align to the frame. Each requester holds its request for the whole frame, and the block samples it only during the requester's own slot. Reads return on a one-cycle valid strobe.

Top module: `shared_word_ram`

## Requirements
- R1: While reset is asserted, `frame_start` is 1, all three read-valid strobes are 0 and all three read-data outputs are 0.
- R2: After reset, `frame_start` is high in exactly one cycle out of every four, starting with the first cycle after reset is released.
- R3: The processor request is sampled in the `frame_start` cycle. `cpu_addr[11:2]` selects the word and `cpu_addr[1:0]` selects the byte lane, where lane 0 is bits 7:0 and lane 3 is bits 31:24. A byte read returns the byte on `cpu_rdata` with `cpu_rvalid` high for one cycle, two cycles after the `frame_start` cycle.
- R4: A processor byte write replaces only the addressed byte of the word. The other three bytes keep their values.
- R5: The compute engine request is sampled two cycles after `frame_start`. A write stores `ce_wdata` as a full word. A read returns the word with `ce_rvalid` high for one cycle, in the next `frame_start` cycle.
- R6: The SPI request is sampled three cycles after `frame_start`. A write stores `spi_wdata` as a full word. A read returns the word with `spi_rvalid` high for one cycle, one cycle after the next `frame_start`.
- R7: A write, or a frame with no request on a port, produces no read-valid strobe on that port.
- R8: When several requesters touch the same word in one frame, their accesses take effect in slot order: processor, then compute engine, then SPI. Each read sees every write made in an earlier slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, four cycles per frame |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | output | 1 | High in the processor slot-A cycle |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | 12 | Processor byte address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte |
| cpu_rvalid | output | 1 | Processor read data valid |
| ce_req | input | 1 | Compute engine access request |
| ce_we | input | 1 | Compute engine write (1) or read (0) |
| ce_addr | input | 10 | Compute engine word address |
| ce_wdata | input | 32 | Compute engine write word |
| ce_rdata | output | 32 | Compute engine read word |
| ce_rvalid | output | 1 | Compute engine read data valid |
| spi_req | input | 1 | SPI access request |
| spi_we | input | 1 | SPI write (1) or read (0) |
| spi_addr | input | 10 | SPI word address |
| spi_wdata | input | 32 | SPI write word |
| spi_rdata | output | 32 | SPI read word |
| spi_rvalid | output | 1 | SPI read data valid |

## Verification
The whole array is first filled through the SPI port. Thousands of random frames follow, with addresses drawn mostly from an eight-word window so that two or three ports often hit the same word in one frame. These frames separate correct slot ordering from any design that lets a later slot's write overtake an earlier read. Directed frames write each of the four byte lanes in turn at the top and bottom words and then read the word back in full. Any lane swap, or any corruption of a neighbouring byte, shows up there. Frames with write-only or idle ports confirm that read strobes appear only for reads, and only in each port's own return cycle.

// File: rtl/shared_word_ram.sv
module shared_word_ram #(
  parameter int WORDS = 1024,
  parameter int WIDTH = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  output logic                               frame_start,
  input  logic                               cpu_req,
  input  logic                               cpu_we,
  input  logic [$clog2(WORDS)+$clog2(WIDTH/8)-1:0] cpu_addr,
  input  logic [7:0]                         cpu_wdata,
  output logic [7:0]                         cpu_rdata,
  output logic                               cpu_rvalid,
  input  logic                               ce_req,
  input  logic                               ce_we,
  input  logic [$clog2(WORDS)-1:0]           ce_addr,
  input  logic [WIDTH-1:0]                   ce_wdata,
  output logic [WIDTH-1:0]                   ce_rdata,
  output logic                               ce_rvalid,
  input  logic                               spi_req,
  input  logic                               spi_we,
  input  logic [$clog2(WORDS)-1:0]           spi_addr,
  input  logic [WIDTH-1:0]                   spi_wdata,
  output logic [WIDTH-1:0]                   spi_rdata,
  output logic                               spi_rvalid
);
  localparam int AW    = $clog2(WORDS);
  localparam int LANES = WIDTH / 8;
  localparam int LW    = $clog2(LANES);

  localparam logic [1:0] SLOT_CPU_A = 2'd0;
  localparam logic [1:0] SLOT_CPU_B = 2'd1;
  localparam logic [1:0] SLOT_CE    = 2'd2;
  localparam logic [1:0] SLOT_SPI   = 2'd3;

  logic [1:0]       slot;
  logic [WIDTH-1:0] mem [WORDS];
  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] merged;
  logic             cpu_act, cpu_wr, ce_rd_p, spi_rd_p;
  logic [AW-1:0]    cpu_word;
  logic [LW-1:0]    cpu_lane;
  logic [7:0]       cpu_byte;

  assign frame_start = (slot == SLOT_CPU_A);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[8*i +: 8] = (cpu_lane == LW'(i)) ? cpu_byte : word_q[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    case (slot)
      SLOT_CPU_A: if (cpu_req) word_q <= mem[cpu_addr[AW+LW-1:LW]];
      SLOT_CPU_B: if (cpu_act && cpu_wr) mem[cpu_word] <= merged;
      SLOT_CE:
        if (ce_req) begin
          if (ce_we) mem[ce_addr] <= ce_wdata;
          else       word_q <= mem[ce_addr];
        end
      default:
        if (spi_req) begin
          if (spi_we) mem[spi_addr] <= spi_wdata;
          else        word_q <= mem[spi_addr];
        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot       <= SLOT_CPU_A;
      cpu_act    <= 1'b0;
      cpu_wr     <= 1'b0;
      cpu_word   <= '0;
      cpu_lane   <= '0;
      cpu_byte   <= '0;
      ce_rd_p    <= 1'b0;
      spi_rd_p   <= 1'b0;
      cpu_rdata  <= '0;
      cpu_rvalid <= 1'b0;
      ce_rdata   <= '0;
      ce_rvalid  <= 1'b0;
      spi_rdata  <= '0;
      spi_rvalid <= 1'b0;
    end else begin
      slot       <= slot + 2'd1;
      cpu_rvalid <= 1'b0;
      ce_rvalid  <= 1'b0;
      spi_rvalid <= 1'b0;
      case (slot)
        SLOT_CPU_A: begin
          cpu_act  <= cpu_req;
          cpu_wr   <= cpu_we;
          cpu_word <= cpu_addr[AW+LW-1:LW];
          cpu_lane <= cpu_addr[LW-1:0];
          cpu_byte <= cpu_wdata;
          if (spi_rd_p) begin
            spi_rdata  <= word_q;
            spi_rvalid <= 1'b1;
          end
        end
        SLOT_CPU_B:
          if (cpu_act && !cpu_wr) begin
            cpu_rdata  <= word_q[8*cpu_lane +: 8];
            cpu_rvalid <= 1'b1;
          end
        SLOT_CE: ce_rd_p <= ce_req && !ce_we;
        default: begin
          spi_rd_p <= spi_req && !spi_we;
          if (ce_rd_p) begin
            ce_rdata  <= word_q;
            ce_rvalid <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module shared_word_ram_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic cpu_req,
  input logic cpu_we,
  input logic cpu_rvalid,
  input logic ce_req,
  input logic ce_we,
  input logic ce_rvalid,
  input logic spi_req,
  input logic spi_we,
  input logic spi_rvalid
);
  logic [1:0] ph;
  always_ff @(posedge clk) begin
    if (!rst_n) ph <= 2'd0;
    else        ph <= ph + 2'd1;
  end

  assert_frame_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start == (ph == 2'd0));
  assert_cpu_valid_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> ph == 2'd2);
  assert_ce_valid_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rvalid |-> ph == 2'd0);
  assert_spi_valid_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_rvalid |-> ph == 2'd1);
  assert_cpu_no_read_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd0 && !(cpu_req && !cpu_we)) |=> ##1 !cpu_rvalid);
  assert_ce_no_read_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd2 && !(ce_req && !ce_we)) |=> ##1 !ce_rvalid);
  assert_spi_no_read_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 2'd3 && !(spi_req && !spi_we)) |=> ##1 !spi_rvalid);
endmodule

bind shared_word_ram shared_word_ram_chk u_chk (.*);

// File: tb/shared_word_ram_bench.sv
`timescale 1ns/1ps
module shared_word_ram_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start;
  logic cpu_req = 0, cpu_we = 0;
  logic [11:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic cpu_rvalid;
  logic ce_req = 0, ce_we = 0;
  logic [9:0]  ce_addr = '0;
  logic [31:0] ce_wdata = '0, ce_rdata;
  logic ce_rvalid;
  logic spi_req = 0, spi_we = 0;
  logic [9:0]  spi_addr = '0;
  logic [31:0] spi_wdata = '0, spi_rdata;
  logic spi_rvalid;

  shared_word_ram u_shared_word_ram (.*);

  always #4 clk = ~clk;

  int nvec = 0, nfail = 0;
  bit done = 0;
  logic [31:0] model [1024];

  function automatic logic [31:0] put_byte(logic [31:0] w, logic [1:0] ln, logic [7:0] b);
    logic [31:0] r = w;
    r[8*ln +: 8] = b;
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input string tg,
      input bit cr, input bit cw, input logic [11:0] ca, input logic [7:0] cd,
      input bit er, input bit ew, input logic [9:0] ea, input logic [31:0] ed,
      input bit sr, input bit sw, input logic [9:0] sa, input logic [31:0] sd);
    logic [31:0] w, exp_e, exp_s;
    logic [7:0] exp_c;
    exp_c = '0; exp_e = '0; exp_s = '0;
    while (!frame_start) @(negedge clk);
    cpu_req = cr; cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
    ce_req = er; ce_we = ew; ce_addr = ea; ce_wdata = ed;
    spi_req = sr; spi_we = sw; spi_addr = sa; spi_wdata = sd;
    if (cr) begin
      w = model[ca[11:2]];
      exp_c = w[8*ca[1:0] +: 8];
      if (cw) model[ca[11:2]] = put_byte(w, ca[1:0], cd);
    end
    if (er) begin
      if (ew) model[ea] = ed; else exp_e = model[ea];
    end
    if (sr) begin
      if (sw) model[sa] = sd; else exp_s = model[sa];
    end
    @(negedge clk);
    @(negedge clk);
    chk((cr && !cw) ? tg : "R7", "cpu_rvalid", 32'(cpu_rvalid), 32'(cr && !cw));
    if (cr && !cw) chk(tg, "cpu_rdata", 32'(cpu_rdata), 32'(exp_c));
    @(negedge clk);
    @(negedge clk);
    chk((er && !ew) ? tg : "R7", "ce_rvalid", 32'(ce_rvalid), 32'(er && !ew));
    if (er && !ew) chk(tg, "ce_rdata", ce_rdata, exp_e);
    cpu_req = 0; ce_req = 0; spi_req = 0;
    @(negedge clk);
    chk((sr && !sw) ? tg : "R7", "spi_rvalid", 32'(spi_rvalid), 32'(sr && !sw));
    if (sr && !sw) chk(tg, "spi_rdata", spi_rdata, exp_s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1", "frame_start", 32'(frame_start), 32'd1);
    chk("R1", "valids", {29'd0, cpu_rvalid, ce_rvalid, spi_rvalid}, 32'd0);
    chk("R1", "cpu_rdata", 32'(cpu_rdata), 32'd0);
    chk("R1", "ce_rdata", ce_rdata, 32'd0);
    chk("R1", "spi_rdata", spi_rdata, 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk("R2", "frame_start", 32'(frame_start), 32'((c % 4) == 3));
    end

    for (int a = 0; a < 1024; a++)
      run_frame("R6", 0, 0, '0, '0, 0, 0, '0, '0, 1, 1, 10'(a), $urandom);

    for (int a = 0; a < 1024; a += 97)
      run_frame("R5", 0, 0, '0, '0, 1, 0, 10'(a), '0, 0, 0, '0, '0);
    run_frame("R5", 0, 0, '0, '0, 1, 1, 10'd1023, 32'hdead_beef, 0, 0, '0, '0);
    run_frame("R6", 0, 0, '0, '0, 0, 0, '0, '0, 1, 0, 10'd1023, '0);

    for (int ln = 0; ln < 4; ln++) begin
      run_frame("R4", 1, 1, {10'd1023, 2'(ln)}, 8'(8'h10 + ln), 0, 0, '0, '0, 0, 0, '0, '0);
      run_frame("R4", 0, 0, '0, '0, 1, 0, 10'd1023, '0, 0, 0, '0, '0);
      run_frame("R4", 1, 1, {10'd0, 2'(ln)}, 8'(8'hA0 + ln), 0, 0, '0, '0, 1, 0, 10'd0, '0);
      run_frame("R3", 1, 0, {10'd0, 2'(ln)}, '0, 0, 0, '0, '0, 0, 0, '0, '0);
      run_frame("R3", 1, 0, {10'd1023, 2'(ln)}, '0, 0, 0, '0, '0, 0, 0, '0, '0);
    end

    run_frame("R8", 1, 1, {10'd5, 2'd2}, 8'h5a, 1, 0, 10'd5, '0, 1, 1, 10'd5, 32'h1234_5678);
    run_frame("R8", 1, 0, {10'd5, 2'd2}, '0, 1, 1, 10'd5, 32'hcafe_f00d, 1, 0, 10'd5, '0);
    run_frame("R7", 1, 1, {10'd6, 2'd1}, 8'h77, 1, 1, 10'd7, 32'h0, 0, 0, '0, '0);
    run_frame("R7", 0, 0, '0, '0, 0, 0, '0, '0, 0, 0, '0, '0);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      logic [9:0] wa, wb, wc;
      wa = r[0] ? 10'($urandom % 8) : 10'($urandom);
      wb = r[1] ? 10'($urandom % 8) : 10'($urandom);
      wc = r[2] ? 10'($urandom % 8) : 10'($urandom);
      run_frame("R8", r[3], r[4], {wa, 2'(r[6:5])}, 8'($urandom),
                r[7], r[8], wb, $urandom, r[9], r[10], wc, $urandom);
    end
    finish_run();
  end
endmodule